// File: doc/BRIEF.md
# Programmable core low-power sequencer

The sequencer steps a processor core into a low-power state and back out under the control of a small program held in a local sequence memory. Software loads the program and a control register over a simple 32-bit register bus. Each 32-bit memory word packs four one-byte commands. A command can set a group of power-control outputs, stall until a wake interrupt arrives, or stall for a programmable number of cycles.

When the core reports that it has executed a wait-for-interrupt instruction, the sequencer starts fetching commands at a software-selected byte address. It stops when it reaches an end-of-sequence byte. A typical program drives the power controls into their sleep setting and then waits for the wake interrupt. After the wake it drives the controls back to their run setting and ends.

A status register shows whether a program is running and which command byte is current. It also has a sticky flag that records a run past the last byte of the memory.

Top module: `lp_seq_top`

## Requirements
- R1: After reset the following all read 0: the enable bit, the start address, `seq_busy`, `pwr_ctl` and the whole status register (offset 0x0C).
- R2: The control register is at byte offset 0x30. Bit 0 is the enable and bits [10:4] are the 7-bit start byte address. Both fields read back as last written. Every other bit reads 0 and is not changed by writes.
- R3: The sequence memory holds 32 words at byte offsets 0x80 + 4*i and reads back as written while idle. Bus reads return data one cycle after `bus_rd_en`. Command byte address b is in word b/4, at bits [8*(b%4)+7 : 8*(b%4)].
- R4: When idle with enable at 1, a rising edge of `core_wfi` starts a run at the start address. The first command takes effect on the third rising clock edge after the edge where `core_wfi` is first seen high. With enable at 0, the edge is ignored and the block stays idle.
- R5: Commands run in ascending byte address order, across word boundaries. A byte whose low nibble is 0 (other than 0x0F) loads its high nibble into `pwr_ctl`. Consecutive commands take effect two cycles apart.
- R6: The byte 0x0F ends the run. Two cycles after the previous command it is reached, `seq_busy` drops. Status then reads busy bit 0 = 0, with bits [10:4] holding the address of the end byte.
- R7: A byte with low nibble 2 stalls for (high nibble + 1) * 16 cycles. Across such a delay, the gap between the two neighbouring `pwr_ctl` updates is that delay plus 4 cycles.
- R8: A byte with low nibble 1 holds the run, with `pwr_ctl` unchanged, until `core_wake` is high. The next command takes effect on the third edge after the edge where the wake is first seen. `core_wake` while idle starts nothing.
- R9: A run that steps past byte address 127 without an end byte continues at address 0. It also sets status bit 1. That bit stays set until a write to offset 0x0C with bit 1 = 1. A write with bit 1 = 0 leaves it set.
- R10: While a run is in progress, sequence memory writes are dropped and a control write of enable = 0 leaves enable at 1. When idle, enable can be cleared.
- R11: Bytes with low nibble 3..15 (other than the byte 0x0F) do nothing except take their two cycles: `pwr_ctl` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 12 | Write byte offset |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rd_addr | input | 12 | Read byte offset |
| bus_rd_data | output | 32 | Read data, valid one cycle after the strobe |
| core_wfi | input | 1 | Core has executed wait-for-interrupt (rising edge starts a run) |
| core_wake | input | 1 | Wake interrupt |
| pwr_ctl | output | 4 | Power-control outputs |
| seq_busy | output | 1 | A run is in progress |

## Verification
Random power-setting programs, placed at random start bytes that fall anywhere within a word, are checked value by value on every second cycle. These runs separate correct byte order and word crossing from lane or address mistakes, and they locate the end byte exactly. Delay programs with random and maximal counts pin down the stall length. A wake program is held waiting while bus writes are attempted, which distinguishes write blocking from plain waiting. A program that starts at byte 124 and crosses 127, running only no-operation bytes until it reaches address 0, covers the wrap, the sticky flag and the no-operation decoding together. Random control and memory writes cover field masking and read-back.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
  localparam int unsigned OFS_STATUS = 'h0C;
  localparam int unsigned OFS_CTRL   = 'h30;
  localparam int unsigned OFS_MEM    = 'h80;
  localparam int unsigned FIELD_LSB  = 4;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned BUSY_BIT   = 0;
  localparam int unsigned ERR_BIT    = 1;
  localparam int unsigned PWR_W      = 4;
  localparam int unsigned NIB_VALS   = 16;
  localparam logic [7:0] CMD_END = 8'h0F;
  localparam logic [3:0] OP_PWR  = 4'd0;
  localparam logic [3:0] OP_WAKE = 4'd1;
  localparam logic [3:0] OP_DLY  = 4'd2;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_DELAY, ST_WAKE
  } seq_state_t;
endpackage

// File: rtl/lp_seq_mem.sv
module lp_seq_mem #(
  parameter int unsigned WORDS  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/lp_seq_regs.sv
module lp_seq_regs
  import lp_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 32,
  parameter int unsigned PC_W   = 7,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  input  logic              err,
  input  logic [PC_W-1:0]   cur_pc,
  output logic              ctrl_en,
  output logic [PC_W-1:0]   ctrl_start,
  output logic              err_clr,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_mem_q,
  output logic [DATA_W-1:0] rd_data_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] MEM_LO = ADDR_W'(OFS_MEM);
  localparam logic [ADDR_W-1:0] MEM_HI = ADDR_W'(OFS_MEM + 4 * WORDS);

  logic              wr_mem, rd_mem;
  logic [ADDR_W-1:0] woff, roff;
  logic [AW-1:0]     widx, ridx;
  logic [DATA_W-1:0] ctrl_val, stat_val;

  assign wr_mem = wr_en && (wr_addr >= MEM_LO) && (wr_addr < MEM_HI);
  assign rd_mem = rd_en && (rd_addr >= MEM_LO) && (rd_addr < MEM_HI);
  assign woff   = wr_addr - MEM_LO;
  assign roff   = rd_addr - MEM_LO;
  assign widx   = AW'(woff >> 2);
  assign ridx   = AW'(roff >> 2);

  // Sequence memory port: writes blocked while a run is in progress
  assign mem_we    = wr_mem && !busy;
  assign mem_en    = mem_we || rd_mem;
  assign mem_addr  = mem_we ? widx : ridx;
  assign mem_wdata = wr_data;

  assign err_clr = wr_en && (wr_addr == A_STAT) && wr_data[ERR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_start <= '0;
    end else if (wr_en && (wr_addr == A_CTRL)) begin
      ctrl_start <= wr_data[FIELD_LSB +: PC_W];
      ctrl_en    <= busy ? (ctrl_en | wr_data[EN_BIT]) : wr_data[EN_BIT];
    end
  end

  always_comb begin
    ctrl_val = '0;
    ctrl_val[EN_BIT] = ctrl_en;
    ctrl_val[FIELD_LSB +: PC_W] = ctrl_start;
    stat_val = '0;
    stat_val[BUSY_BIT] = busy;
    stat_val[ERR_BIT]  = err;
    stat_val[FIELD_LSB +: PC_W] = cur_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mem_q  <= 1'b0;
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_mem_q <= rd_mem;
      if (rd_addr == A_CTRL)      rd_data_q <= ctrl_val;
      else if (rd_addr == A_STAT) rd_data_q <= stat_val;
      else                        rd_data_q <= '0;
    end
  end
endmodule

// File: rtl/lp_seq_engine.sv
module lp_seq_engine
  import lp_seq_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PC_W     = 7,
  parameter int unsigned DLY_UNIT = 16,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned WA_W   = PC_W - LANE_W,
  localparam int unsigned CNT_W  = $clog2(NIB_VALS * DLY_UNIT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PC_W-1:0]   start,
  input  logic              wfi,
  input  logic              wake,
  input  logic              err_clr,
  input  logic [DATA_W-1:0] word,
  output logic [WA_W-1:0]   word_addr,
  output logic              busy,
  output logic              waiting,
  output logic              err,
  output logic [PC_W-1:0]   pc,
  output logic [PWR_W-1:0]  pwr
);
  seq_state_t       state;
  logic             wfi_q;
  logic [CNT_W-1:0] cnt, dly_load;
  logic [7:0]       lane [LANES];
  logic [7:0]       cur_byte;
  logic [3:0]       op, arg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word[g*8 +: 8];
  end

  assign cur_byte  = lane[pc[LANE_W-1:0]];
  assign op        = cur_byte[3:0];
  assign arg       = cur_byte[7:4];
  assign dly_load  = CNT_W'((32'(arg) + 32'd1) * DLY_UNIT - 32'd1);
  assign word_addr = pc[PC_W-1:LANE_W];
  assign busy      = (state != ST_IDLE);
  assign waiting   = (state == ST_WAKE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= '0;
      err   <= 1'b0;
      pwr   <= '0;
      cnt   <= '0;
      wfi_q <= 1'b0;
    end else begin
      wfi_q <= wfi;
      if (err_clr) err <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (en && wfi && !wfi_q) begin
            pc    <= start;
            state <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          if (cur_byte == CMD_END) begin
            state <= ST_IDLE;
          end else begin
            pc <= pc + 1'b1;
            if (pc == '1) err <= 1'b1;
            case (op)
              OP_PWR: begin
                pwr   <= PWR_W'(arg);
                state <= ST_FETCH;
              end
              OP_WAKE: state <= ST_WAKE;
              OP_DLY: begin
                cnt   <= dly_load;
                state <= ST_DELAY;
              end
              default: state <= ST_FETCH;
            endcase
          end
        end
        ST_DELAY: begin
          if (cnt == '0) state <= ST_FETCH;
          else           cnt   <= cnt - 1'b1;
        end
        ST_WAKE: if (wake) state <= ST_FETCH;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lp_seq_top.sv
module lp_seq_top
  import lp_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WORDS    = 32,
  parameter int unsigned DLY_UNIT = 16,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned PC_W = $clog2(WORDS * (DATA_W / 8))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_wr_addr,
  input  logic [DATA_W-1:0] bus_wr_data,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_rd_addr,
  output logic [DATA_W-1:0] bus_rd_data,
  input  logic              core_wfi,
  input  logic              core_wake,
  output logic [PWR_W-1:0]  pwr_ctl,
  output logic              seq_busy
);
  logic              ctrl_en, err_clr, seq_err, wait_wake;
  logic [PC_W-1:0]   ctrl_start, cur_pc;
  logic              mem_en, mem_we, rd_mem_q;
  logic [AW-1:0]     mem_addr, fetch_addr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata, fetch_word, rd_data_q;

  lp_seq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .PC_W(PC_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr_en), .wr_addr(bus_wr_addr), .wr_data(bus_wr_data),
    .rd_en(bus_rd_en), .rd_addr(bus_rd_addr),
    .busy(seq_busy), .err(seq_err), .cur_pc(cur_pc),
    .ctrl_en(ctrl_en), .ctrl_start(ctrl_start), .err_clr(err_clr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rd_mem_q(rd_mem_q), .rd_data_q(rd_data_q)
  );

  lp_seq_mem #(.WORDS(WORDS), .DATA_W(DATA_W)) u_mem (
    .clk(clk),
    .a_en(mem_en), .a_we(mem_we), .a_addr(mem_addr), .a_wdata(mem_wdata),
    .a_rdata(mem_rdata),
    .b_addr(fetch_addr), .b_rdata(fetch_word)
  );

  lp_seq_engine #(.DATA_W(DATA_W), .PC_W(PC_W), .DLY_UNIT(DLY_UNIT)) u_eng (
    .clk(clk), .rst(rst), .en(ctrl_en), .start(ctrl_start),
    .wfi(core_wfi), .wake(core_wake), .err_clr(err_clr),
    .word(fetch_word), .word_addr(fetch_addr),
    .busy(seq_busy), .waiting(wait_wake), .err(seq_err),
    .pc(cur_pc), .pwr(pwr_ctl)
  );

  assign bus_rd_data = rd_mem_q ? mem_rdata : rd_data_q;
endmodule

// File: rtl/lp_seq_chk.sv
module lp_seq_chk #(
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          ctrl_en,
  input logic [PW-1:0] pwr_ctl,
  input logic          err,
  input logic          err_clr,
  input logic          waiting,
  input logic          wake
);
  AST_IDLE_PWR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(pwr_ctl)); // R5
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && !ctrl_en) |=> !busy); // R4
  AST_BUSY_KEEPS_EN: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_en) |=> ctrl_en); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err); // R9
  AST_ERR_FROM_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(busy)); // R9
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (waiting && !wake) |=> (waiting && $stable(pwr_ctl))); // R8
endmodule

bind lp_seq_top lp_seq_chk #(.PW(4)) u_chk (
  .clk(clk), .rst(rst), .busy(seq_busy), .ctrl_en(ctrl_en),
  .pwr_ctl(pwr_ctl), .err(seq_err), .err_clr(err_clr),
  .waiting(wait_wake), .wake(core_wake)
);

// File: tb/lp_seq_top_tb.sv
`timescale 1ns/1ps
module lp_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic [11:0] bus_wr_addr = '0;
  logic [31:0] bus_wr_data = '0;
  logic        bus_rd_en = 1'b0;
  logic [11:0] bus_rd_addr = '0;
  logic [31:0] bus_rd_data;
  logic        core_wfi = 1'b0;
  logic        core_wake = 1'b0;
  logic [3:0]  pwr_ctl;
  logic        seq_busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] prog [128];

  always #10 clk = ~clk;

  lp_seq_top u_dut (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .bus_rd_en(bus_rd_en), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
    .core_wfi(core_wfi), .core_wake(core_wake),
    .pwr_ctl(pwr_ctl), .seq_busy(seq_busy)
  );

  function automatic logic [31:0] pack_word(input int w);
    return {prog[4*w+3], prog[4*w+2], prog[4*w+1], prog[4*w]};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en, input logic [6:0] st);
    return (32'(st) << 4) | 32'(en);
  endfunction

  function automatic logic [31:0] stat_word(input logic b, input logic e, input logic [6:0] p);
    return (32'(p) << 4) | (32'(e) << 1) | 32'(b);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr_en = 1'b1; bus_wr_addr = a; bus_wr_data = d;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd_en = 1'b1; bus_rd_addr = a;
    @(posedge clk); #1;
    bus_rd_en = 1'b0;
    d = bus_rd_data;
  endtask

  task automatic load_prog();
    for (int w = 0; w < 32; w++) bus_wr(12'(32'h80 + 4 * w), pack_word(w));
  endtask

  task automatic fill_end();
    for (int b = 0; b < 128; b++) prog[b] = 8'h0F;
  endtask

  task automatic start_wfi();
    @(posedge clk); #1;
    core_wfi = 1'b1;
  endtask

  task automatic stop_wfi();
    core_wfi = 1'b0;
    steps(2);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] d;
    logic [3:0]  vals [8];
    int n, s, k, dly;
    logic [6:0] st;
    void'($urandom(32'h5EED_1234));

    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    steps(1);

    // R1 reset state
    chk("R1 busy", 32'(seq_busy), 0);
    chk("R1 pwr", 32'(pwr_ctl), 0);
    bus_rd(12'h0C, rd); chk("R1 status", rd, 0);
    bus_rd(12'h30, rd); chk("R1 ctrl", rd, 0);

    // R2 control masking, random data
    for (int i = 0; i < 8; i++) begin
      d = $urandom;
      bus_wr(12'h30, d);
      bus_rd(12'h30, rd);
      chk("R2 ctrl readback", rd, d & 32'h0000_07F1);
    end

    // R3 memory read-back, random words
    for (int i = 0; i < 8; i++) begin
      k = $urandom % 32;
      d = $urandom;
      bus_wr(12'(32'h80 + 4 * k), d);
      bus_rd(12'(32'h80 + 4 * k), rd);
      chk("R3 mem readback", rd, d);
    end

    // R4 R5 R6 random power programs at random start bytes
    for (int it = 0; it < 4; it++) begin
      n = 3 + int'($urandom % 4);
      s = int'($urandom % (126 - n));
      fill_end();
      for (int i = 0; i < n; i++) begin
        vals[i] = 4'(1 + $urandom % 15);
        prog[s + i] = {vals[i], 4'h0};
      end
      load_prog();
      bus_wr(12'h30, ctrl_word(1'b1, 7'(s)));
      start_wfi();
      steps(3);
      chk("R4 busy after start", 32'(seq_busy), 1);
      chk("R5 first value", 32'(pwr_ctl), 32'(vals[0]));
      for (int i = 1; i < n; i++) begin
        steps(2);
        chk("R5 value order", 32'(pwr_ctl), 32'(vals[i]));
      end
      steps(2);
      chk("R6 idle after end", 32'(seq_busy), 0);
      bus_rd(12'h0C, rd);
      chk("R6 status at end", rd, stat_word(1'b0, 1'b0, 7'(s + n)));
      stop_wfi();
    end

    // R7 delay length: random small counts and the largest count
    for (int it = 0; it < 3; it++) begin
      k = (it == 2) ? 15 : int'($urandom % 4);
      dly = (k + 1) * 16;
      fill_end();
      prog[0] = 8'h10; prog[1] = {4'(k), 4'h2}; prog[2] = 8'h20;
      load_prog();
      bus_wr(12'h30, ctrl_word(1'b1, 7'd0));
      start_wfi();
      steps(3);
      chk("R7 before delay", 32'(pwr_ctl), 1);
      n = 0;
      do begin
        steps(1);
        n++;
      end while (pwr_ctl != 4'd2 && n < 400);
      chk("R7 delay gap", 32'(n), 32'(dly + 4));
      steps(2);
      chk("R7 idle", 32'(seq_busy), 0);
      stop_wfi();
    end

    // R11 no-operation bytes keep the output
    fill_end();
    prog[8] = 8'h60; prog[9] = 8'h73; prog[10] = 8'h95; prog[11] = 8'h70;
    load_prog();
    bus_wr(12'h30, ctrl_word(1'b1, 7'd8));
    start_wfi();
    steps(3); chk("R11 set", 32'(pwr_ctl), 6);
    steps(2); chk("R11 nop one", 32'(pwr_ctl), 6);
    steps(2); chk("R11 nop two", 32'(pwr_ctl), 6);
    steps(2); chk("R11 next set", 32'(pwr_ctl), 7);
    steps(2);
    stop_wfi();

    // R9 wrap past 127 with sticky flag
    bus_rd(12'h0C, rd); chk("R9 flag clear before", rd & 32'h2, 0);
    fill_end();
    prog[124] = 8'h03; prog[125] = 8'h13; prog[126] = 8'h83; prog[127] = 8'h03;
    prog[0] = 8'h50;
    load_prog();
    bus_wr(12'h30, ctrl_word(1'b1, 7'd124));
    start_wfi();
    steps(9); chk("R11 nops before wrap", 32'(pwr_ctl), 7);
    steps(2); chk("R9 wrapped command", 32'(pwr_ctl), 5);
    steps(2); chk("R9 idle", 32'(seq_busy), 0);
    stop_wfi();
    bus_rd(12'h0C, rd); chk("R9 status after wrap", rd, stat_word(1'b0, 1'b1, 7'd1));
    bus_wr(12'h0C, 32'h0000_07FD);
    bus_rd(12'h0C, rd); chk("R9 flag kept", rd & 32'h2, 32'h2);
    bus_wr(12'h0C, 32'h2);
    bus_rd(12'h0C, rd); chk("R9 flag cleared", rd & 32'h2, 0);

    // R4 disabled trigger ignored; R8 wake while idle ignored
    fill_end();
    prog[0] = 8'h30; prog[1] = 8'h01; prog[2] = 8'h40;
    load_prog();
    bus_wr(12'h30, ctrl_word(1'b0, 7'd0));
    start_wfi();
    steps(10);
    chk("R4 disabled no run", 32'(seq_busy), 0);
    chk("R4 disabled pwr", 32'(pwr_ctl), 5);
    stop_wfi();
    core_wake = 1'b1; steps(1); core_wake = 1'b0; steps(4);
    chk("R8 idle wake", 32'(seq_busy), 0);

    // R8 R10 wait for wake, blocked writes
    bus_wr(12'h30, ctrl_word(1'b1, 7'd0));
    start_wfi();
    steps(3); chk("R4 enabled run", 32'(pwr_ctl), 3);
    steps(22);
    chk("R8 still waiting", 32'(seq_busy), 1);
    chk("R8 pwr held", 32'(pwr_ctl), 3);
    bus_wr(12'h94, 32'hDEAD_BEEF);
    bus_wr(12'h30, ctrl_word(1'b0, 7'd0));
    bus_rd(12'h30, rd); chk("R10 enable kept", rd & 32'h1, 1);
    bus_rd(12'h94, rd); chk("R10 mem write dropped", rd, 32'h0F0F_0F0F);
    chk("R8 pwr still held", 32'(pwr_ctl), 3);
    @(posedge clk); #1 core_wake = 1'b1;
    steps(1); core_wake = 1'b0;
    steps(2); chk("R8 after wake", 32'(pwr_ctl), 4);
    steps(2); chk("R8 idle after end", 32'(seq_busy), 0);
    stop_wfi();
    bus_rd(12'h0C, rd); chk("R6 status end byte", rd, stat_word(1'b0, 1'b0, 7'd3));
    bus_wr(12'h30, ctrl_word(1'b0, 7'd0));
    bus_rd(12'h30, rd); chk("R10 enable cleared idle", rd & 32'h1, 0);
    st = 7'($urandom);
    bus_wr(12'h94, {25'h0, st});
    bus_rd(12'h94, rd); chk("R3 idle write accepted", rd, {25'h0, st});

    summary();
    $finish;
  end
endmodule